// File: doc/BRIEF.md
# Option-Byte Unlock and Program Controller

A register-mapped controller that guards a one-word option area holding a read-protection byte. Software reaches it through a single-cycle register bus: a request carries write enable, a word address and 32-bit write data, and the response (read data and an error flag) is returned combinationally in the same cycle. Before anything in the option area can change, two key words have to be written in order. The first pair goes to a main key register. A second pair then goes to an option key register, and that second pair is accepted only once the main controller is unlocked.

Once option writes are enabled, software erases the option word in two steps: it sets the erase bit, then sets start. After that it sets the program bit and writes a byte to the option word location. The storage is a behavioural model. Every operation keeps busy high for a fixed, parameterised number of cycles. A programmed byte is kept together with its bitwise inverse in the upper half of the 16-bit word. The option-status register reports read protection whenever the stored byte differs from 0xA5, and reports write protection whenever the write-protection register reads all zeros.

Top module: `opt_ctrl`

## Requirements
- R1: After reset the main controller and the option access are both locked, and busy, end-of-operation and programming-error are clear. The option word reads 0x5AA5, the write-protection register reads all ones (0xFF by default), and the option-status register reads 0. Word addresses: main key 0, option key 1, control 2, status 3, option-status 4, write-protection 5, option word 8. Control bits: [0] program, [1] erase, [2] start (reads 0), [3] option write-enable, [7] lock (reads 1 while main is locked). Status bits: [0] busy, [1] end-of-operation, [2] programming-error. Option-status bits: [0] read-protected, [1] write-protected.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the main key register unlocks the main controller. While main is locked, a write to the option key register or to the control register gets an error response and has no effect.
- R3: Option write-enable becomes set only after 0x45670123 and then 0xCDEF89AB are written to the option key register while main is unlocked.
- R4: A key value that is wrong for its step, whether a wrong word or the right words in the wrong order, gets an error response. After that, the same key register refuses every further write with an error until reset.
- R5: A control write with bit 3 at zero relocks option access. A control write with bit 7 set relocks both main and option access.
- R6: A control write that sets start while the erase bit is already set and write-enable is held starts an erase. Busy then stays high for BUSY_CYCLES cycles, after which the option word reads 0xFFFF and end-of-operation is set.
- R7: With the program bit set, a write to the option word location whose current contents are erased keeps busy high for BUSY_CYCLES cycles. After that the word reads {~b, b}, where b is write-data bits 7:0, and end-of-operation is set.
- R8: A program write to an option word that has not been erased sets programming-error. It does not raise busy and it leaves the word unchanged.
- R9: A control write that requests erase or program while option write-enable is not held is ignored: both bits stay clear, and programming-error is set.
- R10: Every register write made while busy is high is ignored, with no error response. Reads, including reads of the status register, still work.
- R11: Writing 1 to status bit 1 or bit 2 clears end-of-operation or programming-error respectively.
- R12: The read-protected status bit is set exactly when the stored low byte differs from 0xA5. The write-protected bit is set when the write-protection register is zero. That register can be written only while option write-enable is set; a write at any other time gets an error and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request valid |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| err_o | output | 1 | Error response, same cycle |

## Verification
The assertions check several rules on every cycle. Once a key sequencer has locked out, it never recovers. Write-enable rises only in the cycle after the second key is written. A stored option word that is not erased always carries the complement of its low byte in its upper byte. Erase and program requests are never held without option write-enable. Busy falling always coincides with end-of-operation being set. The write-protection register stays frozen while busy. The bench scenarios cover what needs a stimulus history: the exact busy length, the readback values for random bytes, the rejected program on an unerased word, the lockout after a wrong key order, and writes that are dropped during an operation.

// File: rtl/opt_ctrl_pkg.sv
package opt_ctrl_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [31:0] KEY_A = 32'h4567_0123;
  localparam logic [31:0] KEY_B = 32'hCDEF_89AB;
  localparam logic [7:0]  RDP_OPEN = 8'hA5;

  typedef enum logic [3:0] {
    A_MKEY  = 4'd0,
    A_OKEY  = 4'd1,
    A_CTRL  = 4'd2,
    A_STAT  = 4'd3,
    A_OSTAT = 4'd4,
    A_WPROT = 4'd5,
    A_OPTW  = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_OPEN, KS_DEAD} key_state_e;
  typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_PROG} op_e;
endpackage

// File: rtl/opt_key_seq.sv
module opt_key_seq
  import opt_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        en_i,
  input  logic        relock_i,
  input  logic [31:0] key_i,
  output logic        unlocked_o,
  output logic        reject_o
);
  key_state_e state_q, state_d;
  logic       key_ok;

  always_comb begin
    unique case (state_q)
      KS_IDLE: key_ok = (key_i == KEY_A);
      KS_HALF: key_ok = (key_i == KEY_B);
      default: key_ok = 1'b1;
    endcase
  end

  assign reject_o   = wr_i && (!en_i || state_q == KS_DEAD || !key_ok);
  assign unlocked_o = (state_q == KS_OPEN);

  always_comb begin
    state_d = state_q;
    if (state_q != KS_DEAD) begin
      if (relock_i) state_d = KS_IDLE;
      else if (wr_i && en_i) begin
        unique case (state_q)
          KS_IDLE: state_d = key_ok ? KS_HALF : KS_DEAD;
          KS_HALF: state_d = key_ok ? KS_OPEN : KS_DEAD;
          default: state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;
  end

  // R4
  dead_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == KS_DEAD |=> state_q == KS_DEAD);
  // R3
  key_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(wr_i && en_i && key_i == KEY_B));
endmodule

// File: rtl/opt_store.sv
module opt_store
  import opt_ctrl_pkg::*;
#(
  parameter int unsigned LAT = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        erase_i,
  input  logic        prog_i,
  input  logic [7:0]  byte_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        erased_o,
  output logic [15:0] word_o
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  op_e           op_q;
  logic [7:0]    byte_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      op_q     <= OP_NONE;
      byte_q   <= '0;
      word_o   <= {~RDP_OPEN, RDP_OPEN};
      erased_o <= 1'b0;
    end else if (erase_i) begin
      cnt_q <= CW'(LAT);
      op_q  <= OP_ERASE;
    end else if (prog_i) begin
      cnt_q  <= CW'(LAT);
      op_q   <= OP_PROG;
      byte_q <= byte_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CW'(1);
      if (done_o) begin
        op_q <= OP_NONE;
        if (op_q == OP_ERASE) begin
          word_o   <= 16'hFFFF;
          erased_o <= 1'b1;
        end else if (op_q == OP_PROG) begin
          word_o   <= {~byte_q, byte_q};
          erased_o <= 1'b0;
        end
      end
    end
  end

  // R7
  complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erased_o |-> word_o[15:8] == ~word_o[7:0]);
  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(erase_i || prog_i));
endmodule

// File: rtl/opt_ctrl.sv
module opt_ctrl
  import opt_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned BUSY_CYCLES = 5,
  parameter int unsigned WP_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  logic hit_mkey, hit_okey, hit_ctrl, hit_stat, hit_ostat, hit_wprot, hit_optw, hit_any;
  logic wr, busy, done, erased;
  logic main_open, opt_open, rej_m, rej_o;
  logic prog_q, erase_q, eop_q, pgerr_q;
  logic [WP_W-1:0] wprot_q;
  logic [15:0] word;
  logic ctrl_wr, main_lock_req, opt_relock_req, eff_wen, ctrl_deny;
  logic start_erase, optw_wr, start_prog, prog_fail, wprot_wr;

  assign hit_mkey  = addr_i == ADDR_W'(A_MKEY);
  assign hit_okey  = addr_i == ADDR_W'(A_OKEY);
  assign hit_ctrl  = addr_i == ADDR_W'(A_CTRL);
  assign hit_stat  = addr_i == ADDR_W'(A_STAT);
  assign hit_ostat = addr_i == ADDR_W'(A_OSTAT);
  assign hit_wprot = addr_i == ADDR_W'(A_WPROT);
  assign hit_optw  = addr_i == ADDR_W'(A_OPTW);
  assign hit_any   = hit_mkey | hit_okey | hit_ctrl | hit_stat | hit_ostat | hit_wprot | hit_optw;

  // writes are dropped while an operation runs
  assign wr = req_i && we_i && !busy;

  assign ctrl_wr        = wr && hit_ctrl && main_open;
  assign main_lock_req  = ctrl_wr && wdata_i[7];
  assign opt_relock_req = ctrl_wr && (!wdata_i[3] || wdata_i[7]);
  assign eff_wen        = opt_open && wdata_i[3] && !wdata_i[7];
  assign ctrl_deny      = ctrl_wr && !wdata_i[7] && (wdata_i[0] | wdata_i[1]) && !eff_wen;
  assign start_erase    = ctrl_wr && eff_wen && wdata_i[2] && wdata_i[1] && erase_q;
  assign optw_wr        = wr && hit_optw && main_open && opt_open && prog_q;
  assign start_prog     = optw_wr && erased;
  assign prog_fail      = optw_wr && !erased;
  assign wprot_wr       = wr && hit_wprot && opt_open;

  opt_key_seq u_main_key (
    .clk_i, .rst_ni,
    .wr_i       (wr && hit_mkey),
    .en_i       (1'b1),
    .relock_i   (main_lock_req),
    .key_i      (wdata_i),
    .unlocked_o (main_open),
    .reject_o   (rej_m)
  );

  opt_key_seq u_opt_key (
    .clk_i, .rst_ni,
    .wr_i       (wr && hit_okey),
    .en_i       (main_open),
    .relock_i   (opt_relock_req),
    .key_i      (wdata_i),
    .unlocked_o (opt_open),
    .reject_o   (rej_o)
  );

  opt_store #(.LAT(BUSY_CYCLES)) u_store (
    .clk_i, .rst_ni,
    .erase_i  (start_erase),
    .prog_i   (start_prog),
    .byte_i   (wdata_i[7:0]),
    .busy_o   (busy),
    .done_o   (done),
    .erased_o (erased),
    .word_o   (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      eop_q   <= 1'b0;
      pgerr_q <= 1'b0;
      wprot_q <= '1;
    end else begin
      if (ctrl_wr) begin
        prog_q  <= eff_wen && wdata_i[0];
        erase_q <= eff_wen && wdata_i[1];
      end
      if (done) eop_q <= 1'b1;
      else if (wr && hit_stat && wdata_i[1]) eop_q <= 1'b0;
      if (ctrl_deny || prog_fail) pgerr_q <= 1'b1;
      else if (wr && hit_stat && wdata_i[2]) pgerr_q <= 1'b0;
      if (wprot_wr) wprot_q <= wdata_i[WP_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (1'b1)
        hit_ctrl:  rdata_o = {24'd0, ~main_open, 3'd0, opt_open, 1'b0, erase_q, prog_q};
        hit_stat:  rdata_o = {29'd0, pgerr_q, eop_q, busy};
        hit_ostat: rdata_o = {30'd0, wprot_q == '0, word[7:0] != RDP_OPEN};
        hit_wprot: rdata_o = 32'(wprot_q);
        hit_optw:  rdata_o = {16'd0, word};
        default:   rdata_o = '0;
      endcase
    end
  end

  always_comb begin
    err_o = req_i && !hit_any;
    if (wr) begin
      if (hit_mkey && rej_m) err_o = 1'b1;
      if (hit_okey && rej_o) err_o = 1'b1;
      if (hit_ctrl && !main_open) err_o = 1'b1;
      if (hit_optw && !(main_open && opt_open && prog_q)) err_o = 1'b1;
      if (hit_wprot && !opt_open) err_o = 1'b1;
      if (hit_ostat) err_o = 1'b1;
    end
  end

  // R6
  eop_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> eop_q);
  // R10
  busy_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(wprot_q));
  // R9
  op_needs_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_q || prog_q) |-> opt_open);
  // R3
  wen_needs_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_open |-> main_open);
endmodule

// File: tb/opt_ctrl_tb.sv
module opt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 5;

  localparam logic [3:0] MKEY = 4'd0, OKEY = 4'd1, CTRL = 4'd2, STAT = 4'd3,
                         OSTAT = 4'd4, WPROT = 4'd5, OPTW = 4'd8;
  localparam logic [31:0] K1 = 32'h4567_0123, K2 = 32'hCDEF_89AB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  opt_ctrl #(.ADDR_W(4), .BUSY_CYCLES(LAT), .WP_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_word(input logic [7:0] b);
    return {16'd0, ~b, b};
  endfunction
  function automatic logic [31:0] exp_ostat(input logic [7:0] b, input logic wp0);
    return {30'd0, wp0, b != 8'hA5};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1 e = err;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] s;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      rd(STAT, s);
      if (!s[0]) break;
      n++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic erase_prog(input logic [7:0] b);
    logic e; int n;
    wr(CTRL, 32'h0A, e);
    wr(CTRL, 32'h0E, e);
    wait_idle(n);
    wr(STAT, 32'h6, e);
    wr(CTRL, 32'h09, e);
    wr(OPTW, {16'h0, 8'h3C, b}, e);
    wait_idle(n);
    wr(STAT, 32'h6, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic e; logic [31:0] d; int n;
    void'($urandom(32'd2024));
    do_reset();

    // R1 reset state
    rd(CTRL, d);  chk(d == 32'h80, "R1 ctrl", d, 32'h80);
    rd(STAT, d);  chk(d == 32'h0, "R1 stat", d, 32'h0);
    rd(OPTW, d);  chk(d == 32'h5AA5, "R1 word", d, 32'h5AA5);
    rd(OSTAT, d); chk(d == 32'h0, "R1 ostat", d, 32'h0);
    rd(WPROT, d); chk(d == 32'hFF, "R1 wprot", d, 32'hFF);

    // R2 option key and control refused while main locked
    wr(OKEY, K1, e); chk(e, "R2 okey err", {31'd0, e}, 32'h1);
    wr(CTRL, 32'h08, e); chk(e, "R2 ctrl err", {31'd0, e}, 32'h1);
    wr(MKEY, K1, e); wr(MKEY, K2, e);
    chk(!e, "R2 key err", {31'd0, e}, 32'h0);
    rd(CTRL, d); chk(d == 32'h00, "R2 unlocked", d, 32'h0);

    // R9 erase request without write-enable
    wr(CTRL, 32'h02, e);
    rd(CTRL, d); chk(d == 32'h00, "R9 ctrl", d, 32'h0);
    rd(STAT, d); chk(d == 32'h4, "R9 pgerr", d, 32'h4);
    // R11 W1C
    wr(STAT, 32'h4, e);
    rd(STAT, d); chk(d == 32'h0, "R11 clear", d, 32'h0);

    // R3 option unlock
    wr(OKEY, K1, e);
    rd(CTRL, d); chk(d == 32'h00, "R3 half", d, 32'h0);
    wr(OKEY, K2, e);
    rd(CTRL, d); chk(d == 32'h08, "R3 open", d, 32'h08);

    // R5 relock by writing 0 to bit 3, then re-unlock
    wr(CTRL, 32'h00, e);
    rd(CTRL, d); chk(d == 32'h00, "R5 relock", d, 32'h0);
    wr(OKEY, K1, e); wr(OKEY, K2, e);
    rd(CTRL, d); chk(d == 32'h08, "R5 reopen", d, 32'h08);

    // R8 program an unerased word
    wr(CTRL, 32'h09, e);
    wr(OPTW, 32'hBB, e);
    rd(STAT, d); chk(d == 32'h4, "R8 pgerr no busy", d, 32'h4);
    rd(OPTW, d); chk(d == 32'h5AA5, "R8 word kept", d, 32'h5AA5);
    wr(STAT, 32'h4, e);

    // R6 erase with busy length
    wr(CTRL, 32'h0A, e);
    wr(CTRL, 32'h0E, e);
    wait_idle(n);
    chk(n == LAT, "R6 busy cycles", n, LAT);
    rd(OPTW, d); chk(d == 32'hFFFF, "R6 erased", d, 32'hFFFF);
    rd(STAT, d); chk(d == 32'h2, "R6 eop", d, 32'h2);
    wr(STAT, 32'h2, e);
    rd(STAT, d); chk(d == 32'h0, "R11 eop clear", d, 32'h0);

    // R7 program 0xBB, R10 writes during busy dropped
    wr(CTRL, 32'h09, e);
    wr(OPTW, 32'h12BB, e);
    rd(STAT, d); chk(d[0], "R10 busy visible", d, 32'h1);
    wr(WPROT, 32'h00, e); chk(!e, "R10 no err", {31'd0, e}, 32'h0);
    wr(STAT, 32'h2, e);
    wait_idle(n);
    rd(WPROT, d); chk(d == 32'hFF, "R10 wprot kept", d, 32'hFF);
    rd(OPTW, d); chk(d == exp_word(8'hBB), "R7 word", d, exp_word(8'hBB));
    rd(STAT, d); chk(d == 32'h2, "R7 eop", d, 32'h2);
    rd(OSTAT, d); chk(d == exp_ostat(8'hBB, 1'b0), "R12 rdp", d, exp_ostat(8'hBB, 1'b0));
    wr(STAT, 32'h6, e);

    // R7 R12 random bytes, with 0xA5 forced
    for (int i = 0; i < 14; i++) begin
      logic [7:0] b;
      b = (i % 4 == 1) ? 8'hA5 : 8'($urandom);
      erase_prog(b);
      rd(OPTW, d); chk(d == exp_word(b), "R7 rand word", d, exp_word(b));
      rd(OSTAT, d); chk(d == exp_ostat(b, 1'b0), "R12 rand ostat", d, exp_ostat(b, 1'b0));
    end

    // R12 write protection
    wr(CTRL, 32'h08, e);
    wr(WPROT, 32'h00, e);
    rd(OSTAT, d); chk(d[1], "R12 wp flag", d, 32'h2);
    wr(CTRL, 32'h00, e);
    wr(WPROT, 32'h5A, e); chk(e, "R12 wprot err", {31'd0, e}, 32'h1);
    rd(WPROT, d); chk(d == 32'h0, "R12 wprot kept", d, 32'h0);

    // R4 option key wrong order, then lockout
    wr(OKEY, K2, e); chk(e, "R4 wrong order", {31'd0, e}, 32'h1);
    wr(OKEY, K1, e); chk(e, "R4 locked k1", {31'd0, e}, 32'h1);
    wr(OKEY, K2, e);
    rd(CTRL, d); chk(d == 32'h00, "R4 opt stays locked", d, 32'h0);

    // R5 main lock
    wr(CTRL, 32'h80, e);
    rd(CTRL, d); chk(d == 32'h80, "R5 main lock", d, 32'h80);

    // R4 main key wrong value, then lockout
    wr(MKEY, K1, e); wr(MKEY, 32'h1234_5678, e);
    chk(e, "R4 bad key", {31'd0, e}, 32'h1);
    wr(MKEY, K1, e); chk(e, "R4 main locked out", {31'd0, e}, 32'h1);
    wr(MKEY, K2, e);
    rd(CTRL, d); chk(d == 32'h80, "R4 main stays locked", d, 32'h80);

    // R4 lockout clears on reset
    do_reset();
    wr(MKEY, K1, e); wr(MKEY, K2, e);
    rd(CTRL, d); chk(d == 32'h00, "R4 after reset", d, 32'h0);
    rd(OPTW, d); chk(d == 32'h5AA5, "R1 word after reset", d, 32'h5AA5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule